// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

This block is a single-channel event timer. Software reaches it through a small 32-bit register window on a simple APB-style bus. A 64-bit reload value is split over two word registers. A three-bit control word starts and stops the counter, selects its mode and gates the interrupt line. A sticky event flag is cleared by writing a one to it.

The counter runs in one of two modes. In periodic mode it reloads itself each time it reaches zero, so events repeat at a fixed spacing. In single-count mode it fires once and then sits at zero until software stops it and starts it again. Enabling the timer always starts a fresh count from the stored reload value. Software therefore reprograms a count by stopping the timer, writing the new value and starting it again.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The reload value is 64 bits wide. The low word sits at offset 0x00 and the high word at offset 0x04. Both words read back exactly what was written.
- R3: The control word sits at offset 0x10. Bit 0 is run (1 = counting), bit 1 is mode (0 = periodic reload, 1 = single count) and bit 2 is interrupt unmask. Only these three bits are stored; bits 31:3 read as zero.
- R4: With reload value N, the event flag becomes visible N+2 clock cycles after the bus write edge that sets run from 0 to 1.
- R5: In periodic mode, consecutive events are spaced N+1 cycles apart.
- R6: `irq` is high exactly when the unmask bit and the event flag are both set.
- R7: The event flag reads at bit 0 of offset 0x18. Writing 1 to that bit clears the flag. Writing 0 leaves the flag unchanged.
- R8: If a clearing write lands in the same cycle as a new zero event, the flag stays set.
- R9: Reads of any other offset return zero, and writes to those offsets change no register.
- R10: While run is 0 the counter produces no events.
- R11: In single-count mode only one event occurs per enable. Stopping the timer and starting it again produces another event after N+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the counter |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench measures, cycle by cycle, when the first event appears and how far apart periodic events are, using random reload values and modes. An off-by-one in the load or the reload logic shows up as N+1 or N+3 instead of N+2. Reload value zero in periodic mode is driven against a clear write. A design that gave the clear priority would drop the flag for a cycle, and the bench would see it read zero. The single-count case is watched for several periods: a design that reloads in that mode raises a second event, and one that fails to restart on re-enable never fires again. Unmapped offsets are written with all ones and then read back, together with the real registers, to catch decode aliasing.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned REG_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_LOAD0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h18;

    // packed: unmask = bit 2, single = bit 1, run = bit 0
    typedef struct packed {
        logic unmask;
        logic single;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    function automatic logic [ADDR_W-1:0] load_ofs(input int unsigned idx);
        return OFS_LOAD0 + ADDR_W'(idx * (REG_W / 8));
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(REG_W-CTRL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              flag,
    output logic [CNT_W-1:0]  load_val,
    output ctrl_t             ctrl,
    output logic              clr_req,
    output logic [REG_W-1:0]  rdata
);
    localparam int unsigned LOAD_WORDS = CNT_W / REG_W;

    logic [LOAD_WORDS-1:0][REG_W-1:0] load_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_w <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < LOAD_WORDS; i++) begin
                if (addr == load_ofs(i)) begin
                    load_w[i] <= wdata;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < LOAD_WORDS; g++) begin : g_load
            assign load_val[g*REG_W +: REG_W] = load_w[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && addr == OFS_CTRL) begin
            ctrl <= ctrl_from_word(wdata);
        end
    end

    assign clr_req = wr_en && (addr == OFS_STAT) && wdata[0];

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == OFS_CTRL) begin
                rdata = ctrl_to_word(ctrl);
            end else if (addr == OFS_STAT) begin
                rdata[0] = flag;
            end else begin
                for (int i = 0; i < LOAD_WORDS; i++) begin
                    if (addr == load_ofs(i)) begin
                        rdata = load_w[i];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             single,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero_evt
);
    logic             run_d;
    logic             done;
    logic [CNT_W-1:0] cnt;
    logic             start;
    logic             at_zero;

    assign start    = run && !run_d;
    assign at_zero  = (cnt == '0);
    assign zero_evt = run && !start && at_zero && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_d <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
        end else begin
            run_d <= run;
            if (start) begin
                cnt  <= load_val;
                done <= 1'b0;
            end else if (run) begin
                if (at_zero) begin
                    if (single) begin
                        done <= 1'b1;
                    end else begin
                        cnt <= load_val;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/evt_timer_stat.sv
module evt_timer_stat (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    output logic              irq
);
    logic             wr_en;
    logic             rd_en;
    logic [CNT_W-1:0] load_val;
    ctrl_t            ctrl_q;
    logic             clr_req;
    logic             stat_flag;
    logic             zero_evt;

    assign wr_en = psel && penable && pwrite;
    assign rd_en = psel && !pwrite;

    evt_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (paddr),
        .wdata    (pwdata),
        .flag     (stat_flag),
        .load_val (load_val),
        .ctrl     (ctrl_q),
        .clr_req  (clr_req),
        .rdata    (prdata)
    );

    evt_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .single   (ctrl_q.single),
        .load_val (load_val),
        .zero_evt (zero_evt)
    );

    evt_timer_stat u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_evt (zero_evt),
        .clr_req (clr_req),
        .flag    (stat_flag)
    );

    assign irq = ctrl_q.unmask && stat_flag;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
    input logic clk,
    input logic rst,
    input logic irq,
    input logic flag,
    input logic zero_evt,
    input logic clr_req,
    input logic run,
    input logic single,
    input logic unmask
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && !flag));

    // R6
    a_r6_masked_low: assert property (@(posedge clk) disable iff (rst)
        !unmask |-> !irq);

    // R6
    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    // R7
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !zero_evt) |=> !flag);

    // R8
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        zero_evt |=> flag);

    // R10
    a_r10_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !run |-> !zero_evt);

    // R11
    a_r11_single_once: assert property (@(posedge clk) disable iff (rst)
        (zero_evt && single) |=> !zero_evt);

endmodule

bind evt_timer evt_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .flag     (stat_flag),
    .zero_evt (zero_evt),
    .clr_req  (clr_req),
    .run      (ctrl_q.run),
    .single   (ctrl_q.single),
    .unmask   (ctrl_q.unmask)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;

    localparam logic [7:0] A_LO   = 8'h00;
    localparam logic [7:0] A_HI   = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_STAT = 8'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic        cur_unmask = 1'b0;

    evt_timer uut (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .irq     (irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ctrl_word(input logic run, input logic single, input logic unmask);
        return {29'd0, unmask, single, run};
    endfunction

    function automatic int unsigned first_evt(input int unsigned wr_edge, input int unsigned n);
        return wr_edge + n + 2;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1;
        d = prdata;
        psel = 1'b0;
    endtask

    task automatic wait_flag(output int unsigned at, output logic ok);
        logic [31:0] d;
        ok = 1'b0;
        at = 0;
        for (int k = 0; k < 400; k++) begin
            peek(A_STAT, d);
            if (d[0]) begin
                at = cyc;
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic start_timer(input logic [31:0] n, input logic single, input logic unmask,
                               output int unsigned wr_edge);
        bus_write(A_CTRL, 32'd0);
        bus_write(A_STAT, 32'd1);
        bus_write(A_LO, n);
        bus_write(A_HI, 32'd0);
        cur_unmask = unmask;
        bus_write(A_CTRL, ctrl_word(1'b1, single, unmask));
        wr_edge = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0]  d;
        int unsigned  we, t1, t2;
        logic         ok;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        peek(A_LO, d);   check("R1 lo", d, 0);
        peek(A_HI, d);   check("R1 hi", d, 0);
        peek(A_CTRL, d); check("R1 ctrl", d, 0);
        peek(A_STAT, d); check("R1 stat", d, 0);
        check("R1 irq", irq, 0);

        // R2: load words
        bus_write(A_LO, 32'hDEAD_BEEF);
        bus_write(A_HI, 32'h1234_5678);
        peek(A_LO, d); check("R2 lo", d, 32'hDEAD_BEEF);
        peek(A_HI, d); check("R2 hi", d, 32'h1234_5678);

        // R3: control keeps three bits only
        bus_write(A_CTRL, 32'hFFFF_FFF6);
        peek(A_CTRL, d); check("R3 ctrl bits", d, 32'h6);
        bus_write(A_CTRL, 32'd0);

        // R9: unmapped offsets
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        peek(8'h08, d); check("R9 read 08", d, 0);
        peek(8'h14, d); check("R9 read 14", d, 0);
        peek(A_LO, d);  check("R9 lo intact", d, 32'hDEAD_BEEF);
        peek(A_HI, d);  check("R9 hi intact", d, 32'h1234_5678);
        peek(A_CTRL, d); check("R9 ctrl intact", d, 0);
        peek(A_STAT, d); check("R9 stat intact", d, 0);

        // R10: stopped counter raises nothing
        bus_write(A_LO, 32'd0);
        bus_write(A_HI, 32'd0);
        repeat (20) @(negedge clk);
        peek(A_STAT, d); check("R10 idle flag", d, 0);

        // R8: periodic with N=0 fires each cycle; clear must lose
        start_timer(32'd0, 1'b0, 1'b1, we);
        wait_flag(t1, ok);
        check("R4 n0 first", t1, first_evt(we, 0));
        bus_write(A_STAT, 32'd1);
        peek(A_STAT, d); check("R8 set wins", d[0], 1);
        check("R6 irq on", irq, 1);

        // R7: writing zero keeps the flag
        bus_write(A_STAT, 32'd0);
        peek(A_STAT, d); check("R7 w0 keeps", d[0], 1);

        // R10: stop, clear, stays clear
        bus_write(A_CTRL, 32'd0);
        bus_write(A_STAT, 32'd1);
        peek(A_STAT, d); check("R7 w1 clears", d[0], 0);
        check("R6 irq off", irq, 0);
        repeat (30) @(negedge clk);
        peek(A_STAT, d); check("R10 stopped", d[0], 0);

        // R11: single count fires once, restarts on re-enable
        start_timer(32'd5, 1'b1, 1'b0, we);
        wait_flag(t1, ok);
        check("R11 first", t1, first_evt(we, 5));
        check("R6 masked", irq, 0);
        bus_write(A_STAT, 32'd1);
        repeat (40) @(negedge clk);
        peek(A_STAT, d); check("R11 no repeat", d[0], 0);
        bus_write(A_CTRL, 32'd0);
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b0));
        we = cyc;
        wait_flag(t1, ok);
        check("R11 restart", t1, first_evt(we, 5));

        // random mix: R4, R5, R6, R11
        for (int it = 0; it < 30; it++) begin
            logic [31:0] n;
            logic        single, unmask;
            n      = $urandom_range(2, 24);
            single = 1'($urandom_range(0, 1));
            unmask = 1'($urandom_range(0, 1));
            start_timer(n, single, unmask, we);
            wait_flag(t1, ok);
            check("R4 rand first", t1, first_evt(we, n));
            check("R6 rand irq", irq, unmask);
            bus_write(A_STAT, 32'd1);
            if (!single) begin
                wait_flag(t2, ok);
                check("R5 period", t2 - t1, n + 1);
            end else begin
                repeat (2 * n + 6) @(negedge clk);
                peek(A_STAT, d); check("R11 rand once", d[0], 0);
            end
        end

        bus_write(A_CTRL, 32'd0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule